// File: doc/BRIEF.md
# Per-Pin LED Source Selector

This block sits between two LED select registers and eight open-drain LED pads. Each pad has a 2-bit source field; the field either pulls the pad low (LED lit), lets it float (LED dark, or the pad is free as a general-purpose input), or makes the pad track one of two blink waveforms produced elsewhere on the chip. The result is an 8-bit output-enable vector, where a 1 tells the open-drain pad to sink current. The enable vector is registered, so it is free of glitches from decode logic.

Independently of the selection, the eight pad input levels pass through a synchroniser and appear in a read-only input register. A pad that is released can therefore be used as a plain input, and a pad that is driven can be read back to confirm its level. While reset is held, every pad is released and the input register is cleared.

Top module: `led_pin_selector`

## Requirements
- R1: A source field of 2'b00 makes that pin's `padOe` bit 1 (pad pulled low, LED on).
- R2: A source field of 2'b01 makes that pin's `padOe` bit 0 (pad released, LED off, pin usable as an input).
- R3: A source field of 2'b10 makes that pin's `padOe` bit equal to `blinkA`: 1 while `blinkA` is high (on phase), 0 while it is low.
- R4: A source field of 2'b11 makes that pin's `padOe` bit equal to `blinkB`, with the same polarity as R3.
- R5: Pin n (n = 0..3) takes its field from `selLow[2n+1:2n]`; pin n (n = 4..7) takes its field from `selHigh[2(n-4)+1:2(n-4)]`.
- R6: `padOe` is registered: after a rising clock edge it shows the result for the selects and blink levels present at that edge, and holds until the next edge.
- R7: `inputReg[n]` equals the level `padIn[n]` had two rising edges earlier, whatever source pin n has selected.
- R8: While `rstN` is low, `padOe` is all zeros (every pin released) and `inputReg` is all zeros, without waiting for a clock edge.
- R9: `selHigh` = 8'hFA with `selLow` fixed puts pins 4 and 5 on `blinkA` and pins 6 and 7 on `blinkB`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selLow | input | 8 | Source fields for pins 0 to 3, two bits per pin |
| selHigh | input | 8 | Source fields for pins 4 to 7, two bits per pin |
| blinkA | input | 1 | First blink waveform level, 1 = on phase |
| blinkB | input | 1 | Second blink waveform level, 1 = on phase |
| padIn | input | 8 | Raw pad input levels, asynchronous to clk |
| padOe | output | 8 | Open-drain enable per pin, 1 = pull pad low |
| inputReg | output | 8 | Synchronised pad levels |

## Verification
The awkward situation is a blink waveform toggling while neighbouring pins hold different sources, since a pin wired to the wrong waveform or to the wrong field only shows up when the two blink levels differ and the field layout is asymmetric. The stimulus therefore walks every value of one select register against a complemented and rotated pattern in the other, under all four combinations of the two blink levels, and checks every pin of every vector. Input readback is driven with a fresh pattern each cycle, so a synchroniser one stage short or long disagrees with the delayed expectation, and reset is also asserted in the middle of a run with all pins lit to show the asynchronous release.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  localparam int LED_PINS  = 8;
  localparam int FIELD_W   = 2;
  localparam int BANK_PINS = LED_PINS / 2;
  localparam int BANK_W    = BANK_PINS * FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    SRC_ON      = 2'b00,
    SRC_OFF     = 2'b01,
    SRC_BLINK_A = 2'b10,
    SRC_BLINK_B = 2'b11
  } pinSrc_e;

  typedef struct packed {
    logic [LED_PINS-1:0] forceOn;
    logic [LED_PINS-1:0] takeA;
    logic [LED_PINS-1:0] takeB;
  } pinStrobes_t;
endpackage

// File: rtl/led_sel_decode.sv
module led_sel_decode
  import led_sel_pkg::*;
(
  input  logic [BANK_W-1:0] selLow,
  input  logic [BANK_W-1:0] selHigh,
  output pinStrobes_t       strobes
);
  logic [2*BANK_W-1:0] selAll;
  logic [LED_PINS-1:0] onVec;
  logic [LED_PINS-1:0] aVec;
  logic [LED_PINS-1:0] bVec;
  pinSrc_e             codes [LED_PINS];

  assign selAll = {selHigh, selLow};

  // R5: field p sits at bit 2p of the concatenated select word
  for (genvar p = 0; p < LED_PINS; p++) begin : g_field
    assign codes[p] = pinSrc_e'(selAll[p*FIELD_W +: FIELD_W]);
  end

  always_comb begin
    for (int p = 0; p < LED_PINS; p++) begin
      onVec[p] = (codes[p] == SRC_ON);
      aVec[p]  = (codes[p] == SRC_BLINK_A);
      bVec[p]  = (codes[p] == SRC_BLINK_B);
    end
  end

  assign strobes.forceOn = onVec;
  assign strobes.takeA   = aVec;
  assign strobes.takeB   = bVec;
endmodule

// File: rtl/led_sel_drive.sv
module led_sel_drive
  import led_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pinStrobes_t         strobes,
  input  logic                blinkA,
  input  logic                blinkB,
  output logic [LED_PINS-1:0] padOe
);
  logic [LED_PINS-1:0] nextOe;

  always_comb begin
    nextOe = strobes.forceOn;
    if (blinkA) nextOe = nextOe | strobes.takeA;
    if (blinkB) nextOe = nextOe | strobes.takeB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) padOe <= '0;
    else       padOe <= nextOe;
  end

  // R1: pins told to light are pulled low after the edge
  a_r1_on_pulls_low: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((padOe & $past(strobes.forceOn)) == $past(strobes.forceOn)));

  // R2: pins with no source are released
  a_r2_off_releases: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((padOe & ~$past(strobes.forceOn | strobes.takeA | strobes.takeB)) == '0));

  // R3: blink A followers track the sampled blink A level
  a_r3_follow_a: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((padOe & $past(strobes.takeA)) ==
              ($past(blinkA) ? $past(strobes.takeA) : '0)));

  // R4: blink B followers track the sampled blink B level
  a_r4_follow_b: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((padOe & $past(strobes.takeB)) ==
              ($past(blinkB) ? $past(strobes.takeB) : '0)));

  // R8: reset releases every pin
  always @(posedge clk) begin
    if (!rstN) a_r8_reset_release: assert (padOe == '0);
  end
endmodule

// File: rtl/led_pad_sync.sv
module led_pad_sync
  import led_sel_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LED_PINS-1:0] padIn,
  output logic [LED_PINS-1:0] syncOut
);
  localparam int WARM_W = $clog2(STAGES + 1) + 1;

  logic [LED_PINS-1:0] stage [STAGES];
  logic [WARM_W-1:0]   warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= padIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

  // edges seen since reset, saturating; used only to gate the latency check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               warmCnt <= '0;
    else if (warmCnt < WARM_W'(STAGES + 1))  warmCnt <= warmCnt + 1'b1;
  end

  if (STAGES == 2) begin : g_lat_chk
    // R7: readback is the pad level from two edges back
    a_r7_readback_latency: assert property (@(posedge clk) disable iff (!rstN)
      (warmCnt >= WARM_W'(2)) |-> (syncOut == $past(padIn, 2)));
  end

  // R8: input register cleared under reset
  always @(posedge clk) begin
    if (!rstN) a_r8_reset_clear: assert (syncOut == '0);
  end
endmodule

// File: rtl/led_pin_selector.sv
module led_pin_selector
  import led_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BANK_W-1:0]   selLow,
  input  logic [BANK_W-1:0]   selHigh,
  input  logic                blinkA,
  input  logic                blinkB,
  input  logic [LED_PINS-1:0] padIn,
  output logic [LED_PINS-1:0] padOe,
  output logic [LED_PINS-1:0] inputReg
);
  pinStrobes_t strobes;

  led_sel_decode u_decode (
    .selLow  (selLow),
    .selHigh (selHigh),
    .strobes (strobes)
  );

  led_sel_drive u_drive (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .blinkA  (blinkA),
    .blinkB  (blinkB),
    .padOe   (padOe)
  );

  led_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .padIn   (padIn),
    .syncOut (inputReg)
  );
endmodule

// File: tb/led_pin_selector_tb.sv
module led_pin_selector_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] selLow = 8'h55;
  logic [7:0] selHigh = 8'h55;
  logic       blinkA = 1'b0;
  logic       blinkB = 1'b0;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOe;
  logic [7:0] inputReg;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  led_pin_selector u_dut (
    .clk(clk), .rstN(rstN), .selLow(selLow), .selHigh(selHigh),
    .blinkA(blinkA), .blinkB(blinkB), .padIn(padIn),
    .padOe(padOe), .inputReg(inputReg)
  );

  function automatic logic [7:0] expOe(logic [7:0] lo, logic [7:0] hi, logic a, logic b);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) begin
      logic [1:0] c;
      c = (p < 4) ? lo[2*p +: 2] : hi[2*(p-4) +: 2];
      case (c)
        2'b00: r[p] = 1'b1;
        2'b01: r[p] = 1'b0;
        2'b10: r[p] = a;
        default: r[p] = b;
      endcase
    end
    return r;
  endfunction

  // per-pin comparison, tagged by the code the pin carries (R1..R4) and R5 mapping
  task automatic checkPins(logic [7:0] lo, logic [7:0] hi, logic a, logic b);
    logic [7:0] e;
    e = expOe(lo, hi, a, b);
    for (int p = 0; p < 8; p++) begin
      logic [1:0] c;
      string tag;
      c = (p < 4) ? lo[2*p +: 2] : hi[2*(p-4) +: 2];
      case (c)
        2'b00: tag = "R1";
        2'b01: tag = "R2";
        2'b10: tag = "R3";
        default: tag = "R4";
      endcase
      compared++;
      if (padOe[p] !== e[p]) begin
        mismatched++;
        $display("FAIL %s (R5 pin %0d, R6 timing) padOe=%b expected=%b sel=%h/%h a=%b b=%b",
                 tag, p, padOe[p], e[p], lo, hi, a, b);
      end
    end
  endtask

  task automatic checkVec(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] hist1, hist0;
    // R8: reset state before any edge and across edges
    #1;
    checkVec("R8 padOe in reset", padOe, 8'h00);
    checkVec("R8 inputReg in reset", inputReg, 8'h00);
    padIn = 8'hFF;
    selLow = 8'h00;
    repeat (3) @(negedge clk);
    checkVec("R8 padOe held in reset", padOe, 8'h00);
    checkVec("R8 inputReg held in reset", inputReg, 8'h00);
    rstN = 1'b1;

    // R1..R6: every selLow value against a derived selHigh, all blink pairs
    for (int s = 0; s < 256; s++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic [7:0] lo, hi;
        lo = 8'(s);
        hi = ~{lo[1:0], lo[7:2]};
        @(negedge clk);
        selLow = lo; selHigh = hi;
        blinkA = ab[0]; blinkB = ab[1];
        @(negedge clk);
        checkPins(lo, hi, ab[0], ab[1]);
      end
    end

    // R6: output holds between edges after input change
    @(negedge clk);
    selLow = 8'h00; selHigh = 8'h00;
    @(negedge clk);
    #1 selLow = 8'h55; selHigh = 8'h55;
    #1 checkVec("R6 hold until edge", padOe, 8'hFF);
    @(negedge clk);
    checkVec("R6 update after edge", padOe, 8'h00);

    // R9: 8'hFA on the upper bank
    selLow = 8'h55; selHigh = 8'hFA; blinkA = 1'b1; blinkB = 1'b0;
    @(negedge clk);
    checkVec("R9 blinkA phase", padOe, 8'h30);
    blinkA = 1'b0; blinkB = 1'b1;
    @(negedge clk);
    checkVec("R9 blinkB phase", padOe, 8'hC0);
    blinkA = 1'b1;
    @(negedge clk);
    checkVec("R9 both on", padOe, 8'hF0);

    // R7: readback pipeline with a fresh pattern each cycle, selects varying
    padIn = 8'h00;
    @(negedge clk);
    @(negedge clk);
    hist1 = 8'h00; hist0 = 8'h00;
    for (int k = 0; k < 300; k++) begin
      logic [7:0] v;
      v = 8'((k * 37) ^ (k >> 1) ^ 8'hA5);
      selLow = 8'(k); selHigh = 8'(k * 3);
      padIn = v;
      @(negedge clk);
      if (k >= 1) checkVec("R7 readback two edges late", inputReg, hist0);
      hist1 = hist0;
      hist0 = v;
    end

    // R8: asynchronous reset mid-run with every pin lit
    selLow = 8'h00; selHigh = 8'h00; padIn = 8'hFF;
    repeat (3) @(negedge clk);
    checkVec("R1 all lit before reset", padOe, 8'hFF);
    checkVec("R7 readback before reset", inputReg, 8'hFF);
    #1 rstN = 1'b0;
    #1;
    checkVec("R8 async release", padOe, 8'h00);
    checkVec("R8 async clear", inputReg, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1 relit after reset", padOe, 8'hFF);

    finishRun();
  end
endmodule